// File: doc/BRIEF.md
# Overcurrent Fault Flag Controller

This block sits between the two overcurrent comparators of a push-pull output stage and the gate-drive logic. One trip input belongs to the high-side switch and one to the low-side switch. A trip does two things. It forces the matching switch off for a fixed blanking window, which limits current pulse by pulse. It also drives an active-low fault flag low on the next clock edge.

The flag does not drop as soon as the trip goes away. It stays low until a set number of consecutive switching cycles have passed with no trip on either channel. A switching cycle is marked by a rising edge of the active control input. In single-control mode (`mode` = 0) only the low-side control input `ctl_lo` counts. In dual-control mode (`mode` = 1) a rising edge on either `ctl_hi` or `ctl_lo` counts. Driving `enable` low clears the flag and both forced-off requests at the next clock edge, without waiting for the hold count. Driving `rst_n` low clears them at once.

The flag is built by a three-state machine:
- `F_OK`: the flag is released.
- `F_HELD`: a trip was seen and the clean count is zero.
- `F_COUNT`: one or more clean cycles have been counted.

The transitions are:
- `F_OK`→`F_HELD` on a trip.
- `F_HELD`→`F_COUNT` on a clean cycle edge. If the hold count is 1, this edge goes straight to `F_OK`.
- `F_COUNT`→`F_HELD` on a trip.
- `F_COUNT`→`F_OK` on the last clean edge.
- Any state goes to `F_OK` when `enable` is low.

Each channel has its own blanking timer with two states, `B_IDLE` and `B_BLANK`. A trip moves `B_IDLE`→`B_BLANK`. A trip inside `B_BLANK` restarts the window. `B_BLANK`→`B_IDLE` happens when the window runs out or when `enable` is low.

Top module: `ocp_fault_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first clock after its release, `fault_n` is 1 and `kill_hi` and `kill_lo` are 0.
- R2: With `enable` high, a 1 on `trip_hi` or `trip_lo` at a clock edge makes `fault_n` 0 after that edge.
- R3: With `enable` high, a 1 on `trip_hi` at a clock edge makes `kill_hi` 1 for exactly BLANK_CYCLES clocks starting after that edge. `kill_lo` is not affected.
- R4: The low-side channel behaves the same as the high-side one: `trip_lo` drives `kill_lo` for BLANK_CYCLES clocks, and `kill_hi` is not affected.
- R5: A trip that arrives while a channel's window is running restarts that window at its full length.
- R6: `fault_n` returns to 1 at the clock edge that samples the HOLD_CYCLES-th consecutive trip-free cycle edge, and at no other edge except a clear.
- R7: A trip on either channel while the fault is held sets the clean-cycle count back to zero.
- R8: With `mode` = 0, only a 0→1 change of `ctl_lo` counts as a cycle edge. Edges on `ctl_hi` do not move the count.
- R9: With `mode` = 1, a 0→1 change of `ctl_hi` or of `ctl_lo` counts as a cycle edge. Both rising in the same clock count as one edge.
- R10: `enable` low at a clock edge makes `fault_n` 1 and both kill outputs 0 after that edge. Trips sampled while `enable` is low have no effect, and the clean count starts again from zero.
- R11: `rst_n` low forces `fault_n` to 1 and both kill outputs to 0 without waiting for a clock edge.
- R12: A trip and a cycle edge sampled at the same clock edge count as a trip. The count stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the fault at once |
| enable | input | 1 | Active-high enable; low clears the fault and the kill requests |
| mode | input | 1 | 1 = dual control, 0 = single control |
| ctl_hi | input | 1 | High-side control input (counts cycles in dual mode only) |
| ctl_lo | input | 1 | Low-side control input (counts cycles in both modes) |
| trip_hi | input | 1 | Synchronous overcurrent trip from the high-side switch |
| trip_lo | input | 1 | Synchronous overcurrent trip from the low-side switch |
| fault_n | output | 1 | Registered active-low fault flag |
| kill_hi | output | 1 | Force the high-side switch off (blanking window active) |
| kill_lo | output | 1 | Force the low-side switch off (blanking window active) |

## Verification
Directed patterns cover each mechanism on its own:
- A single trip on one channel separates the two blanking channels from each other.
- A trip repeated inside a running window shows whether the window restarts.
- Control pulses on only `ctl_hi` and then only `ctl_lo`, in each mode, show which edges are counted.
- A trip placed between clean edges, or in the same clock as an edge, tells a count that resets from one that only pauses.

Enable-low and asynchronous reset are each applied while a fault is held, to separate an immediate clear from a count-based release. A long stretch of random trips, control toggles, mode changes and enable drops is then compared clock by clock against a behavioural model.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    // Fault flag controller states
    typedef enum logic [1:0] {
        F_OK    = 2'd0,
        F_HELD  = 2'd1,
        F_COUNT = 2'd2
    } fault_state_t;

    // Per-channel blanking timer states
    typedef enum logic {
        B_IDLE  = 1'b0,
        B_BLANK = 1'b1
    } blank_state_t;

    localparam int unsigned NUM_CHAN = 2;
    localparam int unsigned CH_HI    = 0;
    localparam int unsigned CH_LO    = 1;

endpackage

// File: rtl/ocp_cycle_edge.sv
// Marks the start of a switching cycle: a rising edge of the control
// input(s) that the current mode selects.
module ocp_cycle_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic mode,
    input  logic ctl_hi,
    input  logic ctl_lo,
    output logic cyc_edge
);

    logic prev_hi;
    logic prev_lo;
    logic rise_hi;
    logic rise_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_hi <= 1'b0;
            prev_lo <= 1'b0;
        end else begin
            prev_hi <= ctl_hi;
            prev_lo <= ctl_lo;
        end
    end

    always_comb begin
        rise_hi = ctl_hi & ~prev_hi;
        rise_lo = ctl_lo & ~prev_lo;
        if (mode) begin
            cyc_edge = rise_hi | rise_lo;
        end else begin
            cyc_edge = rise_lo;
        end
    end

endmodule

// File: rtl/ocp_blank_timer.sv
// One blanking window per channel: a trip forces the switch off for
// BLANK_CYCLES clocks; a trip inside the window restarts it.
module ocp_blank_timer
    import ocp_pkg::*;
#(
    parameter int unsigned BLANK_CYCLES = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic trip,
    output logic kill
);

    localparam int unsigned BW = (BLANK_CYCLES > 1) ? $clog2(BLANK_CYCLES) : 1;
    localparam logic [BW-1:0] LOAD = BW'(BLANK_CYCLES - 1);

    blank_state_t    state_q, state_d;
    logic [BW-1:0]   cnt_q, cnt_d;
    logic            kill_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= B_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!enable) begin
            state_d = B_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                B_IDLE: begin
                    if (trip) begin
                        state_d = B_BLANK;
                        cnt_d   = LOAD;
                    end
                end
                B_BLANK: begin
                    if (trip) begin
                        cnt_d = LOAD;
                    end else if (cnt_q == '0) begin
                        state_d = B_IDLE;
                    end else begin
                        cnt_d = cnt_q - BW'(1);
                    end
                end
                default: begin
                    state_d = B_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kill_q <= 1'b0;
        end else begin
            kill_q <= (state_d == B_BLANK);
        end
    end

    assign kill = kill_q;

endmodule

// File: rtl/ocp_fault_fsm.sv
// Fault flag: set by any trip, released after HOLD_CYCLES consecutive
// trip-free cycle edges, cleared at once by enable low.
module ocp_fault_fsm
    import ocp_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic trip_any,
    input  logic cyc_edge,
    output logic fault_n
);

    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    fault_state_t    state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            fault_n_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= F_OK;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!enable) begin
            state_d = F_OK;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                F_OK: begin
                    if (trip_any) begin
                        state_d = F_HELD;
                        cnt_d   = '0;
                    end
                end
                F_HELD: begin
                    if (trip_any) begin
                        cnt_d = '0;
                    end else if (cyc_edge) begin
                        if (HOLD_CYCLES == 1) begin
                            state_d = F_OK;
                            cnt_d   = '0;
                        end else begin
                            state_d = F_COUNT;
                            cnt_d   = CW'(1);
                        end
                    end
                end
                F_COUNT: begin
                    if (trip_any) begin
                        state_d = F_HELD;
                        cnt_d   = '0;
                    end else if (cyc_edge) begin
                        if (cnt_q == LAST) begin
                            state_d = F_OK;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                end
                default: begin
                    state_d = F_OK;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // output register, glitch-free flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_n_q <= 1'b1;
        end else begin
            fault_n_q <= (state_d == F_OK);
        end
    end

    assign fault_n = fault_n_q;

endmodule

// File: rtl/ocp_fault_ctrl.sv
module ocp_fault_ctrl
    import ocp_pkg::*;
#(
    parameter int unsigned BLANK_CYCLES = 15,
    parameter int unsigned HOLD_CYCLES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic mode,
    input  logic ctl_hi,
    input  logic ctl_lo,
    input  logic trip_hi,
    input  logic trip_lo,
    output logic fault_n,
    output logic kill_hi,
    output logic kill_lo
);

    logic                cyc_edge;
    logic                trip_any;
    logic [NUM_CHAN-1:0] trip_v;
    logic [NUM_CHAN-1:0] kill_v;

    assign trip_v[CH_HI] = trip_hi;
    assign trip_v[CH_LO] = trip_lo;
    assign trip_any      = |trip_v;

    ocp_cycle_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .ctl_hi   (ctl_hi),
        .ctl_lo   (ctl_lo),
        .cyc_edge (cyc_edge)
    );

    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        ocp_blank_timer #(
            .BLANK_CYCLES (BLANK_CYCLES)
        ) u_blank (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (enable),
            .trip   (trip_v[ch]),
            .kill   (kill_v[ch])
        );
    end

    ocp_fault_fsm #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .trip_any (trip_any),
        .cyc_edge (cyc_edge),
        .fault_n  (fault_n)
    );

    assign kill_hi = kill_v[CH_HI];
    assign kill_lo = kill_v[CH_LO];

endmodule

// File: rtl/ocp_fault_ctrl_chk.sv
module ocp_fault_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic trip_hi,
    input logic trip_lo,
    input logic cyc_edge,
    input logic fault_n,
    input logic kill_hi,
    input logic kill_lo
);

    // R2: a trip while enabled sets the flag
    a_r2_trip_sets_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (trip_hi || trip_lo)) |=> !fault_n);

    // R3: high-side trip forces high side off
    a_r3_trip_kills_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && trip_hi) |=> kill_hi);

    // R4: low-side trip forces low side off
    a_r4_trip_kills_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && trip_lo) |=> kill_lo);

    // R5: a window never ends right after a retriggering trip
    a_r5_no_end_on_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kill_hi) |-> !$past(trip_hi));

    // R6: release only on a cycle edge or an enable clear
    a_r6_release_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n) |-> ($past(cyc_edge) || !$past(enable)));

    // R7: no release in the clock after a trip
    a_r7_no_release_on_trip: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fault_n) && $past(enable)) |-> (!$past(trip_hi) && !$past(trip_lo)));

    // R10: enable low clears everything
    a_r10_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (fault_n && !kill_hi && !kill_lo));

endmodule

bind ocp_fault_ctrl ocp_fault_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .trip_hi  (trip_hi),
    .trip_lo  (trip_lo),
    .cyc_edge (cyc_edge),
    .fault_n  (fault_n),
    .kill_hi  (kill_hi),
    .kill_lo  (kill_lo)
);

// File: tb/ocp_fault_ctrl_bench.sv
module ocp_fault_ctrl_bench;

    localparam int BLANK = 15;
    localparam int HOLD  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic mode = 1'b1;
    logic ctl_hi = 1'b0;
    logic ctl_lo = 1'b0;
    logic trip_hi = 1'b0;
    logic trip_lo = 1'b0;
    logic fault_n, kill_hi, kill_lo;

    int n_checks = 0;
    int n_fail = 0;
    string tag = "R1";

    // behavioural reference model
    bit m_flt = 0;
    int m_cnt = 0;
    int m_bh = 0;
    int m_bl = 0;
    bit m_ph = 0;
    bit m_pl = 0;

    always #4 clk = ~clk;   // 125 MHz

    ocp_fault_ctrl #(.BLANK_CYCLES(BLANK), .HOLD_CYCLES(HOLD)) u_ocp_fault_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .ctl_hi(ctl_hi), .ctl_lo(ctl_lo), .trip_hi(trip_hi), .trip_lo(trip_lo),
        .fault_n(fault_n), .kill_hi(kill_hi), .kill_lo(kill_lo)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flt = 0; m_cnt = 0; m_bh = 0; m_bl = 0; m_ph = 0; m_pl = 0;
        end else begin
            bit edge_seen;
            edge_seen = mode ? ((ctl_hi && !m_ph) || (ctl_lo && !m_pl)) : (ctl_lo && !m_pl);
            m_ph = ctl_hi;
            m_pl = ctl_lo;
            if (!enable) begin
                m_flt = 0; m_cnt = 0; m_bh = 0; m_bl = 0;
            end else begin
                if (trip_hi) m_bh = BLANK; else if (m_bh > 0) m_bh--;
                if (trip_lo) m_bl = BLANK; else if (m_bl > 0) m_bl--;
                if (trip_hi || trip_lo) begin
                    m_flt = 1; m_cnt = 0;
                end else if (m_flt && edge_seen) begin
                    m_cnt++;
                    if (m_cnt == HOLD) begin
                        m_flt = 0; m_cnt = 0;
                    end
                end
            end
        end
    end

    task automatic check(input bit got, input bit exp, input string req, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, got, exp, $time);
        end
    endtask

    // compare against the model every clock, 2 ns after the edge
    always begin
        @(posedge clk);
        #2;
        check(fault_n, !m_flt, tag, "fault_n vs model");
        check(kill_hi, m_bh > 0, tag, "kill_hi vs model");
        check(kill_lo, m_bl > 0, tag, "kill_lo vs model");
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trip(input bit h, input bit l);
        trip_hi = h; trip_lo = l;
        @(negedge clk);
        trip_hi = 0; trip_lo = 0;
    endtask

    task automatic ctl_pulse(input bit h, input bit l);
        ctl_hi = h; ctl_lo = l;
        wait_clk(2);
        ctl_hi = 0; ctl_lo = 0;
        wait_clk(2);
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R1: reset state
        wait_clk(3);
        check(fault_n, 1, "R1", "fault_n in reset");
        check(kill_hi | kill_lo, 0, "R1", "kill in reset");
        rst_n = 1; enable = 1; mode = 1;
        wait_clk(1);
        check(fault_n, 1, "R1", "fault_n after release");

        // R2, R3: high-side trip
        tag = "R3";
        pulse_trip(1, 0);
        check(fault_n, 0, "R2", "fault after hi trip");
        check(kill_hi, 1, "R3", "kill_hi after trip");
        check(kill_lo, 0, "R3", "kill_lo untouched");
        wait_clk(BLANK - 1);
        check(kill_hi, 1, "R3", "kill_hi last window clock");
        wait_clk(1);
        check(kill_hi, 0, "R3", "kill_hi after window");

        // R6: release after HOLD clean edges (dual mode)
        tag = "R6";
        for (int i = 0; i < HOLD - 1; i++) ctl_pulse(0, 1);
        check(fault_n, 0, "R6", "held before last edge");
        ctl_pulse(0, 1);
        check(fault_n, 1, "R6", "released after last edge");

        // R4, R7: low-side trip and count restart
        tag = "R7";
        pulse_trip(0, 1);
        check(kill_lo, 1, "R4", "kill_lo after trip");
        check(kill_hi, 0, "R4", "kill_hi untouched");
        ctl_pulse(0, 1); ctl_pulse(0, 1); ctl_pulse(0, 1);
        pulse_trip(0, 1);
        for (int i = 0; i < HOLD - 1; i++) ctl_pulse(0, 1);
        check(fault_n, 0, "R7", "count restarted by trip");
        ctl_pulse(0, 1);
        check(fault_n, 1, "R7", "released after full count");
        wait_clk(BLANK);

        // R5: retrigger restarts the window
        tag = "R5";
        pulse_trip(1, 0);
        wait_clk(5);
        pulse_trip(1, 0);
        wait_clk(BLANK - 1);
        check(kill_hi, 1, "R5", "window restarted");
        wait_clk(1);
        check(kill_hi, 0, "R5", "restarted window ends");
        for (int i = 0; i < HOLD; i++) ctl_pulse(0, 1);

        // R8: single mode counts only ctl_lo edges
        tag = "R8";
        mode = 0;
        pulse_trip(0, 1);
        for (int i = 0; i < HOLD + 2; i++) ctl_pulse(1, 0);
        check(fault_n, 0, "R8", "ctl_hi ignored in single mode");
        for (int i = 0; i < HOLD; i++) ctl_pulse(0, 1);
        check(fault_n, 1, "R8", "ctl_lo counted in single mode");

        // R9: dual mode counts ctl_hi edges; simultaneous edges count once
        tag = "R9";
        mode = 1;
        pulse_trip(1, 0);
        for (int i = 0; i < HOLD; i++) ctl_pulse(1, 0);
        check(fault_n, 1, "R9", "ctl_hi counted in dual mode");
        pulse_trip(1, 0);
        for (int i = 0; i < HOLD - 1; i++) ctl_pulse(1, 1);
        check(fault_n, 0, "R9", "joint edge counts once");
        ctl_pulse(1, 1);
        check(fault_n, 1, "R9", "released after joint edges");

        // R12: trip and edge in the same clock
        tag = "R12";
        pulse_trip(0, 1);
        ctl_lo = 1; trip_lo = 1;
        wait_clk(1);
        trip_lo = 0;
        wait_clk(1);
        ctl_lo = 0;
        wait_clk(2);
        for (int i = 0; i < HOLD - 1; i++) ctl_pulse(0, 1);
        check(fault_n, 0, "R12", "edge with trip not counted");
        ctl_pulse(0, 1);
        check(fault_n, 1, "R12", "released");

        // R10: enable low clears at once, trips ignored
        tag = "R10";
        pulse_trip(1, 1);
        enable = 0;
        wait_clk(1);
        check(fault_n, 1, "R10", "enable low clears fault");
        check(kill_hi | kill_lo, 0, "R10", "enable low clears kill");
        pulse_trip(1, 1);
        check(fault_n, 1, "R10", "trip ignored while disabled");
        check(kill_hi | kill_lo, 0, "R10", "no kill while disabled");
        enable = 1;
        wait_clk(2);

        // R11: asynchronous reset clears immediately
        tag = "R11";
        pulse_trip(1, 0);
        #1 rst_n = 0;
        #1 check(fault_n, 1, "R11", "async clear of fault");
        check(kill_hi, 0, "R11", "async clear of kill");
        wait_clk(2);
        rst_n = 1;
        wait_clk(2);

        // random stretch compared to the model
        tag = "R6";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            trip_hi = ($urandom % 37) == 0;
            trip_lo = ($urandom % 41) == 0;
            if (($urandom % 3) == 0) ctl_hi = ~ctl_hi;
            if (($urandom % 3) == 0) ctl_lo = ~ctl_lo;
            if (($urandom % 300) == 0) mode = ~mode;
            enable = ($urandom % 250) != 0;
        end
        trip_hi = 0; trip_lo = 0;
        wait_clk(3);
        summary();
    end

endmodule